// File: doc/BRIEF.md
# Edge-Timestamp Capture Unit

This block records when selected edges happen on up to four asynchronous input lines. A shared timebase counts prescaled ticks while capture is globally enabled. Each channel watches its own input. When the input makes the transition that the channel's edge code selects, the channel stores the current timebase count and flags an interrupt. Software works out period and duty from pairs of these timestamps.

The block is set up and read through a simple 32-bit register port. A write takes effect on the clock edge where `bus_req_i` and `bus_we_i` are high. Read data is combinational from `bus_addr_i` while `bus_req_i` is high.

Per-channel status flags sit in bits 4:1. They pass through a matching enable mask onto a single interrupt line. Writing ones to the acknowledge register clears them.

Top module: `edge_capture`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: The edge register of channel n sits at byte offset 0x30+4n and holds a 2-bit code in bits 1:0: 0 off, 1 rising, 2 falling, 3 either edge. Upper bits are dropped and read back as 0.
- R3: On a selected edge, the channel's capture register at 0x10+4n takes the timebase count. The input change is seen at the capture register and status three clock edges later. Two of those edges are the synchroniser stages and one is the capture register. The value stored is the count held after the second of those edges.
- R4: The timebase advances by one every P+1 clocks, where P is control register (0x50) bits 8:4. The first increment lands P+1 edges after the edge that sets the enable.
- R5: Control bit 10 enables capture. While it is 0, the timebase is held at 0 and no channel captures or sets status.
- R6: A capture sets status bit n+1 of register 0x58. If another edge arrives before acknowledge, the bit stays set and the capture value is replaced by the newer count.
- R7: Writing a 1 to bit n+1 of the acknowledge register (0x5C) clears status bit n+1. Writing 0x1FF clears all status bits, and the register reads 0.
- R8: `irq_o` is high exactly when some status bit is set together with its enable bit in register 0x54, bits 4:1.
- R9: A channel whose code is 0 neither captures nor sets status when its input toggles.
- R10: The control register reads back only bits 10 and 8:4. The enable register reads back only bits 4:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| sig_i | input | 4 | Asynchronous inputs to timestamp |
| irq_o | output | 1 | Enabled-status interrupt |

## Verification
Register writes land on the clock edge of the access. The timebase is therefore at 0 on the enable edge E and at floor((k−E)/(P+1)) after edge k.

An input changed between edges, after edge T, reaches the capture register and status on edge T+3. The captured value is the count after edge T+2.

The bench counts edges itself and changes inputs on falling edges. It waits exactly three edges before reading capture, status and `irq_o` a short delay after a falling edge. Expected counts come from that formula.

// File: rtl/edge_cap_pkg.sv
package edge_cap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;

  localparam logic [7:0] CAP_BASE  = 8'h10;
  localparam logic [7:0] MODE_BASE = 8'h30;
  localparam logic [7:0] CTRL_ADDR = 8'h50;
  localparam logic [7:0] IEN_ADDR  = 8'h54;
  localparam logic [7:0] STS_ADDR  = 8'h58;
  localparam logic [7:0] ACK_ADDR  = 8'h5C;

  localparam int CTRL_EN_BIT = 10;
  localparam int PSC_LSB     = 4;
  localparam int FLAG_LSB    = 1;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;

  // R2: an edge pulse lasts one cycle and is never both directions
  p_pulse_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o || fall_o) |=> !(rise_o || fall_o));
  p_dir_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
endmodule

// File: rtl/cap_timebase.sv
module cap_timebase #(
  parameter int CNT_W = 32,
  parameter int PSC_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o
);
  logic [PSC_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;

  // >= keeps the divider bounded if the prescale is lowered mid-count
  assign tick_o = en_i && (div_q >= psc_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (!en_i) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (tick_o) begin
      div_q <= '0;
      cnt_q <= cnt_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  p_hold_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_o == '0);
  p_step_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));
  p_no_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_o) |=> $stable(cnt_o));
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import edge_cap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  edge_mode_e       mode_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cap_q;

  // code bit 0 arms rising, bit 1 arms falling
  assign hit_o = en_i && ((mode_i[0] && rise_i) || (mode_i[1] && fall_i));
  assign cap_o = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_q <= '0;
    else if (hit_o) cap_q <= cnt_i;
  end

  p_latch_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> cap_o == $past(cnt_i));
  p_off_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == EDGE_OFF) |=> $stable(cap_o));
  p_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cap_o));
endmodule

// File: rtl/edge_capture.sv
module edge_capture
  import edge_cap_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int CNT_W       = 32,
  parameter int PSC_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [NUM_CH-1:0] sig_i,
  output logic              irq_o
);
  localparam int FLAG_MSB = FLAG_LSB + NUM_CH - 1;
  localparam int PSC_MSB  = PSC_LSB + PSC_W - 1;

  logic              cap_en_q;
  logic [PSC_W-1:0]  psc_q;
  logic [NUM_CH-1:0] ien_q;
  logic [NUM_CH-1:0] sts_q;
  edge_mode_e        mode_q [NUM_CH];

  logic [CNT_W-1:0]  cnt;
  logic              tick;
  logic [NUM_CH-1:0] rise, fall, hit;
  logic [CNT_W-1:0]  cap [NUM_CH];
  logic [NUM_CH-1:0] ack_clr;
  logic              wr_en;

  assign wr_en = bus_req_i && bus_we_i;

  cap_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_timebase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cap_en_q),
    .psc_i (psc_q),
    .cnt_o (cnt),
    .tick_o(tick)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(sig_i[i]),
      .rise_o (rise[i]),
      .fall_o (fall[i])
    );

    cap_channel #(.CNT_W(CNT_W)) u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (cap_en_q),
      .mode_i(mode_q[i]),
      .rise_i(rise[i]),
      .fall_i(fall[i]),
      .cnt_i (cnt),
      .cap_o (cap[i]),
      .hit_o (hit[i])
    );
  end

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_en_q <= 1'b0;
      psc_q    <= '0;
      ien_q    <= '0;
      for (int i = 0; i < NUM_CH; i++) mode_q[i] <= EDGE_OFF;
    end else if (wr_en) begin
      if (bus_addr_i == CTRL_ADDR) begin
        cap_en_q <= bus_wdata_i[CTRL_EN_BIT];
        psc_q    <= bus_wdata_i[PSC_MSB:PSC_LSB];
      end
      if (bus_addr_i == IEN_ADDR) ien_q <= bus_wdata_i[FLAG_MSB:FLAG_LSB];
      for (int i = 0; i < NUM_CH; i++) begin
        if (bus_addr_i == 8'(MODE_BASE + 4 * i))
          mode_q[i] <= edge_mode_e'(bus_wdata_i[1:0]);
      end
    end
  end

  assign ack_clr = (wr_en && bus_addr_i == ACK_ADDR) ?
                   bus_wdata_i[FLAG_MSB:FLAG_LSB] : '0;

  // a new capture wins over an acknowledge in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~ack_clr) | hit;
  end

  assign irq_o = |(sts_q & ien_q);

  always_comb begin
    bus_rdata_o = '0;
    if (bus_req_i) begin
      unique case (bus_addr_i)
        CTRL_ADDR: begin
          bus_rdata_o[CTRL_EN_BIT]     = cap_en_q;
          bus_rdata_o[PSC_MSB:PSC_LSB] = psc_q;
        end
        IEN_ADDR: bus_rdata_o[FLAG_MSB:FLAG_LSB] = ien_q;
        STS_ADDR: bus_rdata_o[FLAG_MSB:FLAG_LSB] = sts_q;
        default: begin
          for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr_i == 8'(CAP_BASE + 4 * i))  bus_rdata_o = 32'(cap[i]);
            if (bus_addr_i == 8'(MODE_BASE + 4 * i)) bus_rdata_o = 32'(mode_q[i]);
          end
        end
      endcase
    end
  end

  p_sts_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit) |=> (sts_q & $past(hit)) == $past(hit));
  p_sts_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_clr == '0) |=> (sts_q & $past(sts_q)) == $past(sts_q));
  p_ack_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ack_clr & ~hit)) |=> (sts_q & $past(ack_clr & ~hit)) == '0);
  p_no_event_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_q |-> hit == '0);
  p_tick_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> cap_en_q);
endmodule

// File: tb/edge_capture_test.sv
module edge_capture_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] sig = '0;
  logic        irq;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_cap [NCH];
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  edge_capture uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .sig_i(sig), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic toggle(input int ch, output int t);
    sig[ch] = ~sig[ch];
    t = cyc;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_count(input int t, input int e0, input int psc);
    return 32'((t + 2 - e0) / (psc + 1));
  endfunction

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int t, t2, e0;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NCH; i++) exp_cap[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h50, v); chk("R1 ctrl", v, 0);
    rd(8'h54, v); chk("R1 ien", v, 0);
    rd(8'h58, v); chk("R1 sts", v, 0);
    for (int i = 0; i < NCH; i++) begin
      rd(8'(8'h10 + 4*i), v); chk("R1 cap", v, 0);
      rd(8'(8'h30 + 4*i), v); chk("R1 mode", v, 0);
    end
    chk("R1 irq", 32'(irq), 0);

    // R10 readback masks, R2 mode width
    wr(8'h50, 32'hFFFF_FFFF); rd(8'h50, v); chk("R10 ctrl", v, 32'h5F0);
    wr(8'h54, 32'hFFFF_FFFF); rd(8'h54, v); chk("R10 ien", v, 32'h1E);
    wr(8'h3C, 32'hFF); rd(8'h3C, v); chk("R2 mode mask", v, 3);
    wr(8'h50, 0);

    // R5 disabled: no capture even with both-edge code
    wr(8'h34, 3);
    toggle(1, t);
    rd(8'h58, v); chk("R5 sts", v, 0);
    rd(8'h14, v); chk("R5 cap", v, 0);
    chk("R5 irq", 32'(irq), 0);

    // R6 sticky status, overwrite; R4 max prescale on ch0
    wr(8'h38, 3);
    wr(8'h50, 32'h400);
    e0 = cyc;
    repeat (7) @(negedge clk);
    toggle(2, t);
    exp_cap[2] = exp_count(t, e0, 0);
    rd(8'h18, v); chk("R3 first cap", v, exp_cap[2]);
    repeat (5) @(negedge clk);
    toggle(2, t2);
    exp_cap[2] = exp_count(t2, e0, 0);
    rd(8'h18, v); chk("R6 overwrite", v, exp_cap[2]);
    rd(8'h58, v); chk("R6 sticky", v, 32'h8);
    chk("R8 irq on", 32'(irq), 1);
    wr(8'h5C, 32'h10); rd(8'h58, v); chk("R7 other bit kept", v, 32'h8);
    wr(8'h5C, 32'h1FF); rd(8'h58, v); chk("R7 clear all", v, 0);
    chk("R8 irq off", 32'(irq), 0);
    rd(8'h5C, v); chk("R7 ack reads 0", v, 0);

    wr(8'h30, 1);
    wr(8'h50, 0);
    wr(8'h50, 32'h400 | (31 << 4));
    e0 = cyc;
    repeat (70) @(negedge clk);
    toggle(0, t);
    exp_cap[0] = exp_count(t, e0, 31);
    rd(8'h10, v); chk("R4 psc max", v, exp_cap[0]);
    wr(8'h5C, 32'h1FF);

    // random mix
    for (int k = 0; k < 60; k++) begin
      int ch, mode, psc, ien, gap;
      logic rising, match;
      logic [31:0] exp_sts;
      ch = $urandom_range(0, NCH-1);
      mode = $urandom_range(0, 3);
      psc = $urandom_range(0, 7);
      ien = $urandom_range(0, 15);
      gap = $urandom_range(0, 60);
      wr(8'(8'h30 + 4*ch), 32'(mode));
      wr(8'h54, 32'(ien << 1));
      wr(8'h50, 0);
      wr(8'h50, 32'(32'h400 | (psc << 4)));
      e0 = cyc;
      repeat (gap) @(negedge clk);
      rising = !sig[ch];
      toggle(ch, t);
      match = rising ? mode[0] : mode[1];
      if (match) exp_cap[ch] = exp_count(t, e0, psc);
      exp_sts = match ? 32'(1 << (ch + 1)) : 0;
      rd(8'(8'h10 + 4*ch), v);
      chk(mode == 0 ? "R9 cap kept" : "R2/R3 cap", v, exp_cap[ch]);
      rd(8'h58, v); chk(mode == 0 ? "R9 sts" : "R6 sts", v, exp_sts);
      chk("R8 irq", 32'(irq), 32'((exp_sts & 32'(ien << 1)) != 0));
      wr(8'h5C, 32'h1FF);
      rd(8'h58, v); chk("R7 ack", v, 0);
    end

    finish_up();
  end
endmodule